// File: doc/BRIEF.md
# External Interrupt Event Aggregator

This block sits between a set of peripheral event signals and the seven external interrupt request lines of an 8051-style processor core. Every event input is asynchronous. Each one passes through a synchronizer, then an edge detector with a fixed or programmable polarity, and then sets a sticky flag. Lines 0, 1, 3 and 4 each have one source and one primary flag. Lines 2, 5 and 6 combine several sources. Each of those sources has its own enable and its own per-source flag, and the line also keeps a primary flag.

Software reaches the enables, the polarity controls and the flags through a small byte-wide register port. The core's vector acknowledge clears the primary flag of the line being serviced. A per-source flag clears only where software writes a zero to its bit, and a written one leaves the flag alone. A handler can therefore clear one flag with an all-ones-but-one mask. An event that lands while that write is in flight is never lost.

Top module: `xint_hub`

## Requirements
- R1: After reset, every enable, polarity bit, primary flag and per-source flag is 0, and `irq` is 0.
- R2: A change on an event input first becomes visible in a flag after the third rising clock edge that follows it, and never after only two edges.
- R3: A rising edge on `io_evt[0]` or `io_evt[1]` sets primary flag 0 or 1. Falling edges on these inputs have no effect.
- R4: Line 3 responds to `ce_busy`. Its polarity bit is register 2 bit 7: 0 selects the falling edge and 1 selects the rising edge. An edge of the other direction does not set the flag.
- R5: Any change in value of the 3-bit `supply_stat` sets primary flag 4.
- R6: A pulse source `pulse_evt[k]` sets per-source flag k (register 4 bit k) on the edge chosen by register 2 bit 6 (0 falling, 1 rising). The per-source enables for these sources are register 2 bits 3:0. Primary flag 2 is set only by an event on an enabled source.
- R7: Line 5 sources: a falling edge of `ee_busy` sets register 4 bit 4, and a rising edge of `spi_evt` sets register 4 bit 5. The enables for these two sources are register 2 bits 4 and 5.
- R8: Line 6 sources set register 5 flags as follows: bit 0 on a falling edge of `xfer_busy`, bit 1 on a rising edge of `tick_sec`, bit 2 on a rising edge of `tick_min`, bit 3 on a rising edge of `rtc_alarm`. The enables for these sources are register 3 bits 3:0.
- R9: A write to register 4 or 5 clears each per-source flag whose bit in the written byte is 0. Flags under written ones are unchanged.
- R10: An event that sets a flag on the same clock edge as a clear (a software zero-write, or an acknowledge) leaves the flag set.
- R11: `irq[i]` for lines 0, 1, 3 and 4 is the line enable (register 0 bit i) ANDed with primary flag i. For lines 2, 5 and 6 it is the line enable ANDed with the OR of that line's enabled per-source flags, so it stays high until all of those flags are cleared.
- R12: An acknowledge (`ack_valid` with `ack_line`) clears only the primary flag of that line. Register 1 bits 6:0 read the primary flags and ignore writes.
- R13: Register map: 0 holds the line enables (bits 6:0) and 3 holds the line-6 enables. Register 2 holds the polarity bits and the line-2 and line-5 enables. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_evt | input | 2 | Digital I/O events for lines 0 and 1 |
| pulse_evt | input | N_PULSE | Pulse-output events for line 2 |
| ce_busy | input | 1 | Compute-engine busy, line 3 |
| supply_stat | input | STAT_W | Supply status field, line 4 |
| ee_busy | input | 1 | EEPROM busy, line 5 |
| spi_evt | input | 1 | SPI event, line 5 |
| xfer_busy | input | 1 | Transfer busy, line 6 |
| tick_sec | input | 1 | One-second tick, line 6 |
| tick_min | input | 1 | One-minute tick, line 6 |
| rtc_alarm | input | 1 | RTC alarm, line 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ack_valid | input | 1 | Core vector acknowledge |
| ack_line | input | 3 | Line being acknowledged |
| irq | output | 7 | Interrupt request lines |

## Verification
The assertions check on every cycle the properties that hold at the flag level. A set pulse always leaves its flag set on the next cycle, even against a clear. A flag with no clear on it holds. An acknowledge with no competing event empties the primary flag. A change of the supply status is always followed by primary flag 4. Only the bench scenarios can show the behaviour that depends on particular sequences: the exact three-edge latency, which edge each polarity setting selects, that a zero-write clears a flag while a one-write leaves it, and that a line request stays high after its acknowledge until the last enabled per-source flag is cleared.

// File: rtl/xih_pkg.sv
package xih_pkg;
  localparam int N_LINES  = 7;
  localparam int REG_AW   = 3;
  localparam int REG_DW   = 8;
  localparam int N_SRC5   = 2;
  localparam int N_SRC6   = 4;

  typedef enum logic [REG_AW-1:0] {
    A_LINE_EN = 3'd0,
    A_PRIM    = 3'd1,
    A_CTRL25  = 3'd2,
    A_EN6     = 3'd3,
    A_FLG25   = 3'd4,
    A_FLG6    = 3'd5
  } reg_addr_e;

  localparam int POL2_BIT = 6;
  localparam int POL3_BIT = 7;
  localparam int F5_LSB   = 4;
endpackage

// File: rtl/xih_sync.sv
module xih_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= '0;
    else        st_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= '0;
      else        st_q[s] <= st_q[s-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/xih_edge.sv
module xih_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (rise_sel[i]) evt[i] = sig[i] & ~prev_q[i];
      else             evt[i] = ~sig[i] & prev_q[i];
    end
  end
endmodule

// File: rtl/xih_flagbank.sv
module xih_flagbank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  logic [W-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R10: a set pulse wins against any clear on the same edge
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    // R9: with no clear request, a set flag holds
    p_hold_wo_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
  end
endmodule

// File: rtl/xint_hub.sv
module xint_hub
  import xih_pkg::*;
#(
  parameter int N_PULSE     = 4,
  parameter int STAT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         io_evt,
  input  logic [N_PULSE-1:0] pulse_evt,
  input  logic               ce_busy,
  input  logic [STAT_W-1:0]  supply_stat,
  input  logic               ee_busy,
  input  logic               spi_evt,
  input  logic               xfer_busy,
  input  logic               tick_sec,
  input  logic               tick_min,
  input  logic               rtc_alarm,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               ack_valid,
  input  logic [2:0]         ack_line,
  output logic [6:0]         irq
);
  // N_PULSE must lie in 1..4: the line-2 fields share a byte with line 5
  localparam int EW      = 2 + N_PULSE + 7;
  localparam int E_P2    = 2;
  localparam int E_CE    = 2 + N_PULSE;
  localparam int E_EE    = E_CE + 1;
  localparam int E_SPI   = E_CE + 2;
  localparam int E_XFER  = E_CE + 3;
  localparam int E_SEC   = E_CE + 4;
  localparam int E_MIN   = E_CE + 5;
  localparam int E_ALARM = E_CE + 6;
  localparam int SW      = N_PULSE + N_SRC5 + N_SRC6;
  localparam int S5      = N_PULSE;
  localparam int S6      = N_PULSE + N_SRC5;

  // ---------------- synchronizers ----------------
  logic [1:0]         io_s;
  logic [N_PULSE-1:0] pulse_s;
  logic [6:0]         misc_s;
  logic [STAT_W-1:0]  stat_s;

  xih_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_io (
    .clk(clk), .rst_n(rst_n), .din(io_evt), .dout(io_s));
  xih_sync #(.W(N_PULSE), .STAGES(SYNC_STAGES)) u_sync_pulse (
    .clk(clk), .rst_n(rst_n), .din(pulse_evt), .dout(pulse_s));
  xih_sync #(.W(7), .STAGES(SYNC_STAGES)) u_sync_misc (
    .clk(clk), .rst_n(rst_n),
    .din({rtc_alarm, tick_min, tick_sec, xfer_busy, spi_evt, ee_busy, ce_busy}),
    .dout(misc_s));
  xih_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync_stat (
    .clk(clk), .rst_n(rst_n), .din(supply_stat), .dout(stat_s));

  // ---------------- software registers ----------------
  logic [6:0]         line_en_q, line_en_d;
  logic [N_PULSE-1:0] en2_q, en2_d;
  logic [N_SRC5-1:0]  en5_q, en5_d;
  logic [N_SRC6-1:0]  en6_q, en6_d;
  logic               pol2_q, pol2_d, pol3_q, pol3_d;
  logic               we_line, we_ctrl, we_en6;

  always_comb begin
    we_line   = reg_wr && (reg_addr == A_LINE_EN);
    we_ctrl   = reg_wr && (reg_addr == A_CTRL25);
    we_en6    = reg_wr && (reg_addr == A_EN6);
    line_en_d = line_en_q;
    en2_d     = en2_q;
    en5_d     = en5_q;
    en6_d     = en6_q;
    pol2_d    = pol2_q;
    pol3_d    = pol3_q;
    if (we_line) line_en_d = reg_wdata[6:0];
    if (we_ctrl) begin
      en2_d  = reg_wdata[N_PULSE-1:0];
      en5_d  = reg_wdata[F5_LSB +: N_SRC5];
      pol2_d = reg_wdata[POL2_BIT];
      pol3_d = reg_wdata[POL3_BIT];
    end
    if (we_en6) en6_d = reg_wdata[N_SRC6-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_en_q <= '0;
      en2_q     <= '0;
      en5_q     <= '0;
      en6_q     <= '0;
      pol2_q    <= 1'b0;
      pol3_q    <= 1'b0;
    end else begin
      line_en_q <= line_en_d;
      en2_q     <= en2_d;
      en5_q     <= en5_d;
      en6_q     <= en6_d;
      pol2_q    <= pol2_d;
      pol3_q    <= pol3_d;
    end
  end

  // ---------------- edge detection ----------------
  logic [EW-1:0] e_sig, e_rise, e_evt;

  always_comb begin
    e_sig  = {misc_s, pulse_s, io_s};
    e_rise = '0;
    e_rise[1:0]              = 2'b11;
    e_rise[E_P2 +: N_PULSE]  = {N_PULSE{pol2_q}};
    e_rise[E_CE]             = pol3_q;
    e_rise[E_EE]             = 1'b0;
    e_rise[E_SPI]            = 1'b1;
    e_rise[E_XFER]           = 1'b0;
    e_rise[E_SEC]            = 1'b1;
    e_rise[E_MIN]            = 1'b1;
    e_rise[E_ALARM]          = 1'b1;
  end

  xih_edge #(.W(EW)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig(e_sig), .rise_sel(e_rise), .evt(e_evt));

  logic [STAT_W-1:0] stat_prev_q;
  logic              stat_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_prev_q <= '0;
    else        stat_prev_q <= stat_s;
  end
  assign stat_chg = |(stat_s ^ stat_prev_q);

  // ---------------- per-source flags ----------------
  logic [SW-1:0] s_set, s_clr, s_flag;
  logic [N_PULSE-1:0] ev2;
  logic [N_SRC5-1:0]  ev5;
  logic [N_SRC6-1:0]  ev6;
  logic [N_PULSE-1:0] f2;
  logic [N_SRC5-1:0]  f5;
  logic [N_SRC6-1:0]  f6;
  logic               we_f25, we_f6;

  always_comb begin
    ev2    = e_evt[E_P2 +: N_PULSE];
    ev5    = {e_evt[E_SPI], e_evt[E_EE]};
    ev6    = {e_evt[E_ALARM], e_evt[E_MIN], e_evt[E_SEC], e_evt[E_XFER]};
    s_set  = {ev6, ev5, ev2};
    we_f25 = reg_wr && (reg_addr == A_FLG25);
    we_f6  = reg_wr && (reg_addr == A_FLG6);
    s_clr  = '0;
    if (we_f25) begin
      s_clr[N_PULSE-1:0]  = ~reg_wdata[N_PULSE-1:0];
      s_clr[S5 +: N_SRC5] = ~reg_wdata[F5_LSB +: N_SRC5];
    end
    if (we_f6) s_clr[S6 +: N_SRC6] = ~reg_wdata[N_SRC6-1:0];
  end

  xih_flagbank #(.W(SW)) u_sflags (
    .clk(clk), .rst_n(rst_n), .set(s_set), .clr(s_clr), .flag(s_flag));

  assign f2 = s_flag[N_PULSE-1:0];
  assign f5 = s_flag[S5 +: N_SRC5];
  assign f6 = s_flag[S6 +: N_SRC6];

  // ---------------- primary flags ----------------
  logic [6:0] p_set, p_clr, p_flag;

  always_comb begin
    p_set[0] = e_evt[0];
    p_set[1] = e_evt[1];
    p_set[2] = |(ev2 & en2_q);
    p_set[3] = e_evt[E_CE];
    p_set[4] = stat_chg;
    p_set[5] = |(ev5 & en5_q);
    p_set[6] = |(ev6 & en6_q);
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_pclr
    assign p_clr[l] = ack_valid && (ack_line == 3'(l));
    // R12: an acknowledge with no competing event empties the flag
    p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_line == 3'(l) && !p_set[l]) |=> !p_flag[l]);
  end

  xih_flagbank #(.W(N_LINES)) u_pflags (
    .clk(clk), .rst_n(rst_n), .set(p_set), .clr(p_clr), .flag(p_flag));

  // R5: a change of the synchronized status is followed by flag 4
  p_stat_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_s) |=> p_flag[4]);

  // ---------------- requests ----------------
  always_comb begin
    irq[0] = line_en_q[0] & p_flag[0];
    irq[1] = line_en_q[1] & p_flag[1];
    irq[2] = line_en_q[2] & (|(f2 & en2_q));
    irq[3] = line_en_q[3] & p_flag[3];
    irq[4] = line_en_q[4] & p_flag[4];
    irq[5] = line_en_q[5] & (|(f5 & en5_q));
    irq[6] = line_en_q[6] & (|(f6 & en6_q));
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LINE_EN: reg_rdata[6:0] = line_en_q;
      A_PRIM:    reg_rdata[6:0] = p_flag;
      A_CTRL25: begin
        reg_rdata[N_PULSE-1:0]        = en2_q;
        reg_rdata[F5_LSB +: N_SRC5]   = en5_q;
        reg_rdata[POL2_BIT]           = pol2_q;
        reg_rdata[POL3_BIT]           = pol3_q;
      end
      A_EN6:     reg_rdata[N_SRC6-1:0] = en6_q;
      A_FLG25: begin
        reg_rdata[N_PULSE-1:0]        = f2;
        reg_rdata[F5_LSB +: N_SRC5]   = f5;
      end
      A_FLG6:    reg_rdata[N_SRC6-1:0] = f6;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/xint_hub_tb_top.sv
module xint_hub_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] io_evt = '0;
  logic [3:0] pulse_evt = '0;
  logic       ce_busy = 1'b0;
  logic [2:0] supply_stat = '0;
  logic       ee_busy = 1'b0, spi_evt = 1'b0, xfer_busy = 1'b0;
  logic       tick_sec = 1'b0, tick_min = 1'b0, rtc_alarm = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [6:0] irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  xint_hub dut_i (
    .clk(clk), .rst_n(rst_n), .io_evt(io_evt), .pulse_evt(pulse_evt),
    .ce_busy(ce_busy), .supply_stat(supply_stat), .ee_busy(ee_busy),
    .spi_evt(spi_evt), .xfer_busy(xfer_busy), .tick_sec(tick_sec),
    .tick_min(tick_min), .rtc_alarm(rtc_alarm), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_line(ack_line), .irq(irq));

  // monitor: compare each expected item against the live outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] it;
      logic [7:0] act;
      string      tg;
      it  = exp_q.pop_front();
      tg  = tag_q.pop_front();
      act = it[8] ? {1'b0, irq} : reg_rdata;
      n_checks++;
      if (act !== it[7:0]) begin
        n_fails++;
        $display("FAIL %s: got %02h expected %02h", tg, act, it[7:0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    ack_valid = 1'b1; ack_line = l;
    tick(1);
    ack_valid = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string tg);
    reg_addr = a;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(tg);
    @(negedge clk);
    tick(1);
  endtask

  task automatic chk_irq(input logic [6:0] e, input string tg);
    exp_q.push_back({2'b10, e});
    tag_q.push_back(tg);
    @(negedge clk);
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    for (int a = 0; a < 8; a++) chk_rd(3'(a), 8'h00, "R1 reset register");
    chk_irq(7'h00, "R1 reset irq");

    wr(3'd0, 8'h7F);
    chk_rd(3'd0, 8'h7F, "R13 line enable readback");

    // R2 / R3 lines 0 and 1
    io_evt[0] = 1'b1;
    tick(2);
    chk_rd(3'd1, 8'h00, "R2 not after two edges");
    chk_rd(3'd1, 8'h01, "R2 set after third edge");
    chk_irq(7'h01, "R11 line 0 request");
    ack(3'd0);
    chk_rd(3'd1, 8'h00, "R3 ack clears line 0");
    chk_irq(7'h00, "R11 line 0 request drops");
    io_evt[0] = 1'b0;
    tick(4);
    chk_rd(3'd1, 8'h00, "R3 falling edge ignored");
    io_evt[1] = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h02, "R3 line 1 rising");
    io_evt[0] = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h03, "R3 both lines");
    ack(3'd0);
    chk_rd(3'd1, 8'h02, "R12 ack clears only line 0");
    ack(3'd1);
    chk_rd(3'd1, 8'h00, "R12 ack line 1");
    wr(3'd1, 8'h7F);
    chk_rd(3'd1, 8'h00, "R12 primary flags ignore writes");

    // R4 line 3 polarity
    ce_busy = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h00, "R4 rising ignored when falling selected");
    ce_busy = 1'b0;
    tick(3);
    chk_rd(3'd1, 8'h08, "R4 falling edge");
    chk_irq(7'h08, "R11 line 3 request");
    ack(3'd3);
    wr(3'd2, 8'h80);
    ce_busy = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h08, "R4 rising edge selected");
    ack(3'd3);
    chk_rd(3'd1, 8'h00, "R4 ack line 3");

    // R5 status change
    supply_stat = 3'd5;
    tick(3);
    chk_rd(3'd1, 8'h10, "R5 status change");
    ack(3'd4);
    supply_stat = 3'd4;
    tick(3);
    chk_rd(3'd1, 8'h10, "R5 second change");
    ack(3'd4);

    // R6 line 2 pulse sources
    pulse_evt[1] = 1'b1;
    tick(3);
    chk_rd(3'd4, 8'h00, "R6 rising ignored with falling polarity");
    pulse_evt[1] = 1'b0;
    tick(3);
    chk_rd(3'd4, 8'h02, "R6 falling sets source flag");
    chk_rd(3'd1, 8'h00, "R6 disabled source no primary");
    chk_irq(7'h00, "R11 disabled source no request");
    wr(3'd2, 8'hC2);
    chk_irq(7'h04, "R11 enabling pending source raises request");
    chk_rd(3'd2, 8'hC2, "R13 control readback");
    pulse_evt[1] = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h04, "R6 enabled rising sets primary 2");
    ack(3'd2);
    chk_rd(3'd1, 8'h00, "R12 ack line 2");
    chk_irq(7'h04, "R11 request held by source flag");
    wr(3'd4, 8'hFD);
    chk_rd(3'd4, 8'h00, "R9 zero clears line 2 flag");
    chk_irq(7'h00, "R11 request drops after clear");

    // R8 line 6 sources
    wr(3'd3, 8'h0F);
    xfer_busy = 1'b1;
    tick(3);
    chk_rd(3'd5, 8'h00, "R8 xfer rising ignored");
    xfer_busy = 1'b0;
    tick(3);
    chk_rd(3'd5, 8'h01, "R8 xfer falling");
    tick_sec = 1'b1; tick_min = 1'b1; rtc_alarm = 1'b1;
    tick(3);
    chk_rd(3'd5, 8'h0F, "R8 all line 6 sources");
    chk_rd(3'd1, 8'h40, "R8 primary 6");
    chk_irq(7'h40, "R11 line 6 request");
    wr(3'd5, 8'hFF);
    chk_rd(3'd5, 8'h0F, "R9 ones ignored");
    wr(3'd5, 8'hFA);
    chk_rd(3'd5, 8'h0A, "R9 mask clears bits 0 and 2");
    chk_irq(7'h40, "R11 remaining flags hold request");
    ack(3'd6);
    chk_rd(3'd1, 8'h00, "R12 ack line 6");
    chk_irq(7'h40, "R11 request survives ack");
    wr(3'd5, 8'hF0);
    chk_rd(3'd5, 8'h00, "R9 clear rest");
    chk_irq(7'h00, "R11 line 6 request drops");

    // R7 line 5 sources
    wr(3'd2, 8'hF2);
    ee_busy = 1'b1;
    tick(3);
    chk_rd(3'd4, 8'h00, "R7 ee rising ignored");
    ee_busy = 1'b0;
    tick(3);
    chk_rd(3'd4, 8'h10, "R7 ee falling");
    spi_evt = 1'b1;
    tick(3);
    chk_rd(3'd4, 8'h30, "R7 spi rising");
    chk_rd(3'd1, 8'h20, "R7 primary 5");
    chk_irq(7'h20, "R11 line 5 request");
    wr(3'd4, 8'hCF);
    chk_rd(3'd4, 8'h00, "R9 clear line 5 flags");
    ack(3'd5);
    chk_rd(3'd1, 8'h00, "R12 ack line 5");
    chk_irq(7'h00, "R11 line 5 request drops");

    // R10 event beats zero-write clear
    tick_sec = 1'b0;
    tick(3);
    tick_sec = 1'b1;
    tick(3);
    chk_rd(3'd5, 8'h02, "R8 second tick sets flag");
    tick_sec = 1'b0;
    tick(3);
    tick_sec = 1'b1;
    tick(2);
    wr(3'd5, 8'hFD);
    chk_rd(3'd5, 8'h02, "R10 event wins over clear write");
    wr(3'd5, 8'hFD);
    chk_rd(3'd5, 8'h00, "R9 clear without event");
    ack(3'd6);

    // R10 event beats acknowledge
    io_evt[0] = 1'b0;
    tick(3);
    io_evt[0] = 1'b1;
    tick(3);
    chk_rd(3'd1, 8'h01, "R3 line 0 set again");
    io_evt[0] = 1'b0;
    tick(3);
    io_evt[0] = 1'b1;
    tick(2);
    ack(3'd0);
    chk_rd(3'd1, 8'h01, "R10 event wins over ack");
    ack(3'd0);
    chk_rd(3'd1, 8'h00, "R12 ack after race");

    tick(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule